// File: doc/BRIEF.md
# Mode-Configurable Multiply-Accumulate Unit

This block is a three-stage pipelined arithmetic unit. Its multiplier array is split or joined according to a static mode input: eight independent 9x9 products, four independent 18x18 products, or one 36x36 product. A post-multiply stage then does one of two things. It adds or subtracts pairs of products, or it keeps a running sum of four 18x18 products in a 52-bit accumulator. The block accepts a new operand set on every clock.

Two 72-bit operand buses carry the operand slices. Per-cycle controls choose the signedness of each operand and choose addition or subtraction. An accumulator-clear input restarts the running sum. A valid strobe travels with the data, and each result appears on an 80-bit bus with its own valid flag.

The mode may change only while no valid data is in the pipeline.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `result` is 0 and the accumulator holds 0.
- R2: A set of inputs sampled with `in_valid`=1 on a rising edge appears with `out_valid`=1 just after the second following rising edge. That makes three registers in total, and the count is the same in every mode. Back-to-back valid inputs give back-to-back results, and `out_valid` is 0 in every other cycle.
- R3: With `mode`=0 (narrow pairs), slice j (j=0..7) of each operand is bits [9j+8:9j], and Pj is the product of the two slices. Field k (k=0..3) of `result`, bits [20k+19:20k], holds P(2k)+P(2k+1), or P(2k)-P(2k+1) when `sub`=1. The field is a 20-bit two's complement value.
- R4: With `mode`=1 (half pairs), slice i (i=0..3) of each operand is bits [18i+17:18i], and Qi is the product of the two slices. Field m (m=0,1) of `result`, bits [40m+39:40m], holds Q(2m)+Q(2m+1), or the difference when `sub`=1. The field is a 40-bit two's complement value.
- R5: With `mode`=2 (wide), `result` is the exact product of `op_a[35:0]` and `op_b[35:0]` as an 80-bit two's complement value. Operand bits 71:36 have no effect.
- R6: When `sgn_a`=1, every slice of `op_a` is read as two's complement; otherwise every slice is read as unsigned. `sgn_b` does the same for `op_b`. Both controls may change on every cycle, and no result loses precision.
- R7: `sub` is sampled with each valid input. In pair modes it selects first-minus-second. In accumulate mode it selects accumulator-minus-term.
- R8: With `mode`=3 (accumulate), each valid input forms a term equal to Q0+Q1+Q2+Q3 (slices as in R4). The accumulator becomes acc+term, or acc-term when `sub`=1. `result[51:0]` shows the new accumulator value and `result[79:52]` is 0.
- R9: `acc_clr`=1 on a valid accumulate input replaces the stored sum, so the accumulator becomes 0+term or 0-term.
- R10: Accumulator arithmetic wraps modulo 2^52.
- R11: The accumulator changes only on valid inputs in accumulate mode. It keeps its value across idle cycles and across traffic in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 narrow pairs, 1 half pairs, 2 wide product, 3 accumulate; static while the pipeline holds data |
| in_valid | input | 1 | Operand set present this cycle |
| sgn_a | input | 1 | Treat slices of `op_a` as two's complement |
| sgn_b | input | 1 | Treat slices of `op_b` as two's complement |
| sub | input | 1 | Subtract instead of add |
| acc_clr | input | 1 | Restart the running sum with this term |
| op_a | input | 72 | First operand bus |
| op_b | input | 72 | Second operand bus |
| out_valid | output | 1 | Result present this cycle |
| result | output | 80 | Result bus, field layout set by mode |

## Verification
Each result is due just after the second rising edge that follows the edge that captured its inputs. The bench turns every rising edge into one entry of a queue, whether or not the input is valid. At each falling edge it compares the oldest entry against `out_valid` and `result`, so both the value and its exact cycle are checked. The accumulator model is updated when the entry is made, which keeps back-to-back accumulate terms in the order the hardware sees them. Mode changes are only made after four idle cycles.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int BASE_W  = 9;                 // narrowest slice
    localparam int HALF_W  = 2 * BASE_W;        // 18-bit slice
    localparam int WIDE_W  = 2 * HALF_W;        // 36-bit operand
    localparam int LANES   = 4;                 // lanes in the array
    localparam int OPW     = LANES * HALF_W;    // operand bus width
    localparam int BIGP_W  = 2 * (HALF_W + 1);  // lane product width
    localparam int SMLP_W  = 2 * (BASE_W + 1);  // narrow product width
    localparam int ACC_W   = 52;
    localparam int RES_W   = 80;
    localparam int F9_W    = RES_W / LANES;     // narrow pair field
    localparam int F18_W   = RES_W / 2;         // half pair field

    typedef enum logic [1:0] {
        MODE_PAIR9  = 2'd0,
        MODE_PAIR18 = 2'd1,
        MODE_WIDE36 = 2'd2,
        MODE_ACC18  = 2'd3
    } mac_mode_e;

    typedef struct packed {
        logic           valid;
        logic           sgn_a;
        logic           sgn_b;
        logic           sub;
        logic           clr;
        logic [OPW-1:0] a;
        logic [OPW-1:0] b;
    } in_stage_t;

    typedef struct packed {
        logic                         valid;
        logic                         sub;
        logic                         clr;
        logic [LANES-1:0][BIGP_W-1:0] big;
        logic [LANES-1:0][SMLP_W-1:0] sml;
    } prod_stage_t;

    // Prefix one extension bit: sign copy when signed, zero otherwise.
    function automatic logic signed [BASE_W:0] ext_narrow(
        input logic [BASE_W-1:0] v, input logic s);
        return {s & v[BASE_W-1], v};
    endfunction

    function automatic logic signed [HALF_W:0] ext_half(
        input logic [HALF_W-1:0] v, input logic s);
        return {s & v[HALF_W-1], v};
    endfunction

endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage
    import mac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           sgn_a,
    input  logic           sgn_b,
    input  logic           sub,
    input  logic           acc_clr,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output in_stage_t      s1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.sgn_a <= sgn_a;
            s1.sgn_b <= sgn_b;
            s1.sub   <= sub;
            s1.clr   <= acc_clr;
            s1.a     <= op_a;
            s1.b     <= op_b;
        end
    end

endmodule

// File: rtl/mac_mul_array.sv
module mac_mul_array
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  mac_mode_e   mode,
    input  in_stage_t   s1,
    output prod_stage_t s2
);

    logic [LANES-1:0][BIGP_W-1:0] big_d;
    logic [LANES-1:0][SMLP_W-1:0] sml_d;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            // Wide mode routing: lanes in the upper half take the high half
            // of A, odd lanes take the high half of B.
            localparam bit A_HI = (k >= LANES / 2);
            localparam bit B_HI = ((k % 2) == 1);
            localparam int A_OFS = A_HI ? HALF_W : 0;
            localparam int B_OFS = B_HI ? HALF_W : 0;

            logic [HALF_W-1:0]        a_slc, b_slc, a_w, b_w;
            logic signed [HALF_W:0]   ma, mb;
            logic signed [BASE_W:0]   na, nb;
            logic signed [BIGP_W-1:0] pb;
            logic signed [SMLP_W-1:0] ps;

            assign a_slc = s1.a[HALF_W*k +: HALF_W];
            assign b_slc = s1.b[HALF_W*k +: HALF_W];
            assign a_w   = s1.a[A_OFS +: HALF_W];
            assign b_w   = s1.b[B_OFS +: HALF_W];

            always_comb begin
                unique case (mode)
                    MODE_PAIR9: begin
                        ma = ext_narrow(a_slc[BASE_W-1:0], s1.sgn_a);
                        mb = ext_narrow(b_slc[BASE_W-1:0], s1.sgn_b);
                    end
                    MODE_WIDE36: begin
                        ma = ext_half(a_w, s1.sgn_a & A_HI);
                        mb = ext_half(b_w, s1.sgn_b & B_HI);
                    end
                    MODE_PAIR18, MODE_ACC18: begin
                        ma = ext_half(a_slc, s1.sgn_a);
                        mb = ext_half(b_slc, s1.sgn_b);
                    end
                endcase
            end

            // Second narrow multiplier: only its product reaches the result
            // in the narrow-pair mode.
            assign na = ext_narrow(a_slc[HALF_W-1:BASE_W], s1.sgn_a);
            assign nb = ext_narrow(b_slc[HALF_W-1:BASE_W], s1.sgn_b);

            assign pb = ma * mb;
            assign ps = na * nb;
            assign big_d[k] = pb;
            assign sml_d[k] = ps;

            // R6: unsigned operands never give a negative lane product.
            p_unsigned_nonneg_r6: assert property (@(posedge clk) disable iff (rst)
                (s1.valid && !s1.sgn_a && !s1.sgn_b)
                |=> (!s2.big[k][BIGP_W-1] && !s2.sml[k][SMLP_W-1]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.valid <= s1.valid;
            s2.sub   <= s1.sub;
            s2.clr   <= s1.clr;
            s2.big   <= big_d;
            s2.sml   <= sml_d;
        end
    end

    p_prod_follow_r2: assert property (@(posedge clk) disable iff (rst)
        s2.valid == $past(s1.valid));

endmodule

// File: rtl/mac_post_stage.sv
module mac_post_stage
    import mac_pkg::*;
#(
    parameter int ACC_WIDTH = ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  mac_mode_e        mode,
    input  prod_stage_t      s2,
    output logic             out_valid,
    output logic [RES_W-1:0] result
);

    logic signed [RES_W-1:0] bx [LANES];
    logic [RES_W-1:0]        res_d;
    logic [ACC_WIDTH-1:0]    acc_q, acc_d, term, base;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_ext
            assign bx[k] = $signed(s2.big[k]);
        end
    endgenerate

    always_comb begin
        term = '0;
        for (int i = 0; i < LANES; i++) begin
            term = term + ACC_WIDTH'(bx[i]);
        end
        base  = s2.clr ? '0 : acc_q;
        acc_d = s2.sub ? (base - term) : (base + term);

        res_d = '0;
        unique case (mode)
            MODE_PAIR9: begin
                for (int i = 0; i < LANES; i++) begin
                    res_d[F9_W*i +: F9_W] = s2.sub
                        ? (s2.big[i][F9_W-1:0] - s2.sml[i])
                        : (s2.big[i][F9_W-1:0] + s2.sml[i]);
                end
            end
            MODE_PAIR18: begin
                for (int i = 0; i < LANES / 2; i++) begin
                    res_d[F18_W*i +: F18_W] = s2.sub
                        ? (F18_W'(bx[2*i]) - F18_W'(bx[2*i+1]))
                        : (F18_W'(bx[2*i]) + F18_W'(bx[2*i+1]));
                end
            end
            MODE_WIDE36: begin
                res_d = bx[0] + (bx[1] << HALF_W) + (bx[2] << HALF_W)
                      + (bx[3] << (2 * HALF_W));
            end
            MODE_ACC18: begin
                res_d = RES_W'(acc_d);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            acc_q     <= '0;
        end else begin
            out_valid <= s2.valid;
            if (s2.valid) begin
                result <= res_d;
            end
            if (s2.valid && mode == MODE_ACC18) begin
                acc_q <= acc_d;
            end
        end
    end

    p_out_follow_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(s2.valid));

    p_acc_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(s2.valid && mode == MODE_ACC18) |=> $stable(acc_q));

    p_acc_shown_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode == MODE_ACC18)
        |-> (result[ACC_WIDTH-1:0] == acc_q && result[RES_W-1:ACC_WIDTH] == '0));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             in_valid,
    input  logic             sgn_a,
    input  logic             sgn_b,
    input  logic             sub,
    input  logic             acc_clr,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic             out_valid,
    output logic [RES_W-1:0] result
);

    mac_mode_e   mode_e;
    in_stage_t   s1;
    prod_stage_t s2;

    assign mode_e = mac_mode_e'(mode);

    mac_in_stage u_in (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sgn_a    (sgn_a),
        .sgn_b    (sgn_b),
        .sub      (sub),
        .acc_clr  (acc_clr),
        .op_a     (op_a),
        .op_b     (op_b),
        .s1       (s1)
    );

    mac_mul_array u_mul (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_e),
        .s1   (s1),
        .s2   (s2)
    );

    mac_post_stage #(.ACC_WIDTH(ACC_W)) u_post (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .s2        (s2),
        .out_valid (out_valid),
        .result    (result)
    );

    // R2: the fixed latency holds only if mode moves while the pipe is empty.
    p_mode_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> (!s1.valid && !s2.valid && !out_valid));

endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
    import mac_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       mode;
    logic             in_valid, sgn_a, sgn_b, sub, acc_clr;
    logic [OPW-1:0]   op_a, op_b;
    logic             out_valid;
    logic [RES_W-1:0] result;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_unit u_dut (
        .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
        .sgn_a(sgn_a), .sgn_b(sgn_b), .sub(sub), .acc_clr(acc_clr),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
    );

    typedef struct {
        bit               valid;
        logic [RES_W-1:0] res;
        string            tag;
    } exp_t;

    exp_t             exp_q[$];
    logic [ACC_W-1:0] m_acc;
    int               n_cmp = 0;
    int               n_bad = 0;
    int               cyc   = 0;
    bit               done  = 0;
    string            cur_tag = "R1";

    function automatic logic signed [RES_W-1:0] sx(
        input logic [WIDE_W-1:0] v, input int w, input bit s);
        logic [RES_W-1:0] m;
        logic [RES_W-1:0] r;
        m = (RES_W'(1) << w) - 1;
        r = RES_W'(v) & m;
        if (s && v[w-1]) r = r | ~m;
        return r;
    endfunction

    // Behavioural reference: one queue entry per rising edge.
    always @(posedge clk) begin
        exp_t e;
        logic signed [RES_W-1:0] x, y, t;
        logic [ACC_W-1:0] base;
        e.valid = 0;
        e.res   = '0;
        e.tag   = cur_tag;
        if (rst) begin
            m_acc = '0;
        end else if (in_valid) begin
            e.valid = 1;
            case (mode)
                2'd0: for (int k = 0; k < 4; k++) begin
                    x = sx(op_a[18*k +: 9], 9, sgn_a) * sx(op_b[18*k +: 9], 9, sgn_b);
                    y = sx(op_a[18*k+9 +: 9], 9, sgn_a) * sx(op_b[18*k+9 +: 9], 9, sgn_b);
                    t = sub ? x - y : x + y;
                    e.res[20*k +: 20] = t[19:0];
                end
                2'd1: for (int m = 0; m < 2; m++) begin
                    x = sx(op_a[36*m +: 18], 18, sgn_a) * sx(op_b[36*m +: 18], 18, sgn_b);
                    y = sx(op_a[36*m+18 +: 18], 18, sgn_a) * sx(op_b[36*m+18 +: 18], 18, sgn_b);
                    t = sub ? x - y : x + y;
                    e.res[40*m +: 40] = t[39:0];
                end
                2'd2: e.res = sx(op_a[35:0], 36, sgn_a) * sx(op_b[35:0], 36, sgn_b);
                default: begin
                    t = '0;
                    for (int i = 0; i < 4; i++)
                        t = t + sx(op_a[18*i +: 18], 18, sgn_a) * sx(op_b[18*i +: 18], 18, sgn_b);
                    base  = acc_clr ? '0 : m_acc;
                    m_acc = sub ? base - t[ACC_W-1:0] : base + t[ACC_W-1:0];
                    e.res = RES_W'(m_acc);
                end
            endcase
        end
        exp_q.push_back(e);
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() >= 3 && !done) begin
            e = exp_q.pop_front();
            n_cmp++;
            if (out_valid !== e.valid) begin
                n_bad++;
                $display("FAIL R2 (%s): out_valid actual %b expected %b", e.tag, out_valid, e.valid);
            end else if (e.valid && result !== e.res) begin
                n_bad++;
                $display("FAIL %s: result actual %h expected %h", e.tag, result, e.res);
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, actual %0d cycles expected under %0d", cyc, WATCHDOG);
            finish_up();
        end
    end

    task automatic drive(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                         input bit sa, input bit sb, input bit sb_sub, input bit clr);
        in_valid = 1; op_a = a; op_b = b;
        sgn_a = sa; sgn_b = sb; sub = sb_sub; acc_clr = clr;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 0; op_a = '0; op_b = '0; acc_clr = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        idle(4);
        mode = m;
        idle(1);
    endtask

    function automatic logic [OPW-1:0] rnd72();
        return OPW'({$urandom, $urandom, $urandom});
    endfunction

    initial begin
        rst = 1; mode = 2'd0; in_valid = 0; sgn_a = 0; sgn_b = 0;
        sub = 0; acc_clr = 0; op_a = '0; op_b = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        n_cmp++;
        if (out_valid !== 1'b0 || result !== '0) begin
            n_bad++;
            $display("FAIL R1: valid/result actual %b/%h expected 0/0", out_valid, result);
        end

        // R3: narrow pairs, corners then random
        cur_tag = "R3";
        drive({8{9'h1FF}}, {8{9'h1FF}}, 0, 0, 0, 0);
        drive({8{9'h100}}, {8{9'h100}}, 1, 1, 0, 0);
        drive({8{9'h100}}, {8{9'h0FF}}, 1, 0, 1, 0);
        cur_tag = "R7";
        drive({8{9'h001}}, {4{9'h1FF, 9'h002}}, 0, 0, 1, 0);
        cur_tag = "R6";
        for (int i = 0; i < 40; i++)
            drive(rnd72(), rnd72(), i[0], i[1], i[2], 0);
        idle(2);

        // R4: half pairs
        set_mode(2'd1);
        cur_tag = "R4";
        drive({4{18'h3FFFF}}, {4{18'h3FFFF}}, 0, 0, 0, 0);
        drive({4{18'h20000}}, {4{18'h20000}}, 1, 1, 0, 0);
        drive({4{18'h20000}}, {4{18'h1FFFF}}, 1, 0, 1, 0);
        cur_tag = "R6";
        for (int i = 0; i < 40; i++)
            drive(rnd72(), rnd72(), i[1], i[0], i[2], 0);

        // R5: wide product, upper bits are noise
        set_mode(2'd2);
        cur_tag = "R5";
        drive({36'hABCDE1234, 36'hFFFFFFFFF}, {36'h123456789, 36'hFFFFFFFFF}, 0, 0, 0, 0);
        drive({36'h0, 36'h800000000}, {36'hFFFFFFFFF, 36'h800000000}, 1, 1, 0, 0);
        drive({36'h0, 36'h800000000}, {36'h0, 36'hFFFFFFFFF}, 1, 0, 0, 0);
        drive({36'h0, 36'hFFFFFFFFF}, {36'h0, 36'h800000000}, 0, 1, 0, 0);
        cur_tag = "R6";
        for (int i = 0; i < 40; i++)
            drive(rnd72(), rnd72(), i[0], i[2], 0, 0);

        // R8 / R9: accumulate with clears and subtraction
        set_mode(2'd3);
        cur_tag = "R9";
        drive(rnd72(), rnd72(), 1, 1, 0, 1);
        cur_tag = "R8";
        for (int i = 0; i < 30; i++)
            drive(rnd72(), rnd72(), i[0], i[1], i[2], 0);
        cur_tag = "R9";
        drive(rnd72(), rnd72(), 0, 0, 1, 1);
        cur_tag = "R7";
        drive({4{18'h00005}}, {4{18'h00003}}, 0, 0, 1, 0);
        idle(3);

        // R11: other-mode traffic must leave the sum untouched
        set_mode(2'd0);
        cur_tag = "R3";
        for (int i = 0; i < 8; i++)
            drive(rnd72(), rnd72(), 1, 0, 0, 1);
        set_mode(2'd3);
        cur_tag = "R11";
        drive({4{18'h00001}}, {4{18'h00001}}, 0, 0, 0, 0);

        // R10: wrap below zero, then wrap past the top
        cur_tag = "R10";
        drive({4{18'h00001}}, {4{18'h00001}}, 0, 0, 1, 1);
        drive({4{18'h3FFFF}}, {4{18'h3FFFF}}, 0, 0, 0, 1);
        for (int i = 0; i < 20000; i++)
            drive({4{18'h3FFFF}}, {4{18'h3FFFF}}, 0, 0, 0, 0);
        idle(6);
        finish_up();
    end

endmodule